// File: doc/BRIEF.md
# Single-Cycle Load-Store Processor Core

This block is a 32-bit processor core that retires one instruction on every clock edge. A single rising edge commits the program counter, the general register file and any data-memory store together. Fetch, decode, register read, arithmetic, data access and write-back all settle within one cycle. Instructions arrive through a word-wide instruction port, and loads and stores go through a separate data port. Both memories sit outside the core, read combinationally and written on the clock edge.

A purely combinational decoder turns the opcode, the function field and a zero test on the first source register into a fixed set of route selections. These pick the immediate form, a register or immediate second operand, the ALU operation, and one of three destinations (rt, rd or the link register 31). They also pick one of three write-back sources (ALU, load data, PC+4) and one of four next-PC sources (sequential, PC-relative branch, register, absolute). A debug view presents the current PC and every committed register write.

Encodings (hex): opcode 00 is register-register, with func 20 add, 22 sub, 24 and, 25 or, 26 xor, 2A set-less-than (signed), 08 register jump, 09 register jump-and-link. The immediate opcodes are 08 add, 0A set-less-than, 0C and, 0D or, 0E xor, 0F load-upper. The memory opcodes are 23 word load and 2B word store. The control opcodes are 04 branch-if-zero, 05 branch-if-nonzero, 02 jump and 03 jump-and-link. Fields: opcode [31:26], rs [25:21], rt [20:16], rd [15:11], func [5:0], immediate [15:0], jump index [25:0]. Addresses are byte addresses.

Top module: `sc_core`

## Requirements
- R1: Register 0 reads as zero. Any write aimed at it is dropped and does not raise the debug write strobe.
- R2: A register written by one instruction is seen with its new value by the next instruction.
- R3: Register-register ops (func 20/22/24/25/26/2A) write rd with rs op rt. Set-less-than compares as signed and gives 1 or 0.
- R4: Immediate ops write rt. Add (08) and set-less-than (0A) sign-extend the immediate. And/or/xor (0C/0D/0E) zero-extend it. Load-upper (0F) places it in bits [31:16] with zeros below.
- R5: A word load (23) reads address rs + sign-extended displacement and writes that word into rt.
- R6: A word store (2B) writes rt to address rs + sign-extended displacement for exactly one edge, and writes no register.
- R7: Branch-if-zero (04) and branch-if-nonzero (05) test rs. When taken, the next PC is PC+4 + (sign-extended immediate × 4); otherwise it is PC+4. Neither writes a register.
- R8: Jump (02) and jump-and-link (03) go to {PC+4[31:28], index, 2'b00}. Jump-and-link writes PC+4 into register 31.
- R9: Register jump (func 08) sets the next PC to rs. Register jump-and-link (func 09) does the same and writes PC+4 into rd.
- R10: A control transfer takes effect on the next instruction; the instruction after it in memory is not executed.
- R11: An unrecognised opcode or function code writes neither a register nor memory, and the PC advances by 4.
- R12: While reset is held, and until its synchronised release, the PC stays at RESET_PC and no store or register write occurs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_ni | input | 1 | Asynchronous active-low reset, released synchronously inside |
| imem_addr_o | output | 32 | Byte address of the instruction being fetched |
| imem_rdata_i | input | 32 | Instruction word at imem_addr_o |
| dmem_addr_o | output | 32 | Byte address of a load or store |
| dmem_wdata_o | output | 32 | Store data |
| dmem_we_o | output | 1 | Store strobe, sampled by memory on the rising edge |
| dmem_rdata_i | input | 32 | Load data at dmem_addr_o |
| dbg_pc_o | output | 32 | PC of the instruction executing this cycle |
| dbg_wr_en_o | output | 1 | A register write commits at the coming edge |
| dbg_wr_idx_o | output | 5 | Destination register of that write |
| dbg_wr_data_o | output | 32 | Value written |

## Verification
Every cycle, the assertions check sequential PC advance for non-transfer instructions and not-taken branches. They also check that a written register reads back on the following cycle, that register 0 stays zero after a write attempt, that stores and unknown codes never write a register, that the jump-and-link target is register 31 with PC+4, and that the core is quiet under reset. The arithmetic results, the three immediate extensions, the load and store addressing with negative displacements, the taken-branch and jump targets, and the skipping of instructions after a transfer can only be shown by the bench's program. Its scoreboard compares every committed write and store, in order, against values worked out from the requirements.

// File: rtl/sc_pkg.sv
package sc_pkg;
  localparam int XLEN   = 32;
  localparam int NREG   = 32;
  localparam int RIDX_W = $clog2(NREG);
  localparam int OPC_W  = 6;

  localparam logic [OPC_W-1:0] OPC_RTYPE = 6'h00;
  localparam logic [OPC_W-1:0] OPC_J     = 6'h02;
  localparam logic [OPC_W-1:0] OPC_JAL   = 6'h03;
  localparam logic [OPC_W-1:0] OPC_BZ    = 6'h04;
  localparam logic [OPC_W-1:0] OPC_BNZ   = 6'h05;
  localparam logic [OPC_W-1:0] OPC_ADDI  = 6'h08;
  localparam logic [OPC_W-1:0] OPC_SLTI  = 6'h0A;
  localparam logic [OPC_W-1:0] OPC_ANDI  = 6'h0C;
  localparam logic [OPC_W-1:0] OPC_ORI   = 6'h0D;
  localparam logic [OPC_W-1:0] OPC_XORI  = 6'h0E;
  localparam logic [OPC_W-1:0] OPC_LUI   = 6'h0F;
  localparam logic [OPC_W-1:0] OPC_LW    = 6'h23;
  localparam logic [OPC_W-1:0] OPC_SW    = 6'h2B;

  localparam logic [5:0] FN_JR   = 6'h08;
  localparam logic [5:0] FN_JALR = 6'h09;
  localparam logic [5:0] FN_ADD  = 6'h20;
  localparam logic [5:0] FN_SUB  = 6'h22;
  localparam logic [5:0] FN_AND  = 6'h24;
  localparam logic [5:0] FN_OR   = 6'h25;
  localparam logic [5:0] FN_XOR  = 6'h26;
  localparam logic [5:0] FN_SLT  = 6'h2A;

  typedef enum logic [1:0] {EXT_SIGN, EXT_ZERO, EXT_HIGH} ext_sel_e;
  typedef enum logic [1:0] {DST_RT, DST_RD, DST_LINK} dst_sel_e;
  typedef enum logic [1:0] {WB_ALU, WB_MEM, WB_LINK} wb_sel_e;
  typedef enum logic [1:0] {PC_SEQ, PC_BR, PC_REG, PC_ABS} pc_sel_e;
  typedef enum logic [2:0] {ALU_ADD, ALU_SUB, ALU_AND, ALU_OR, ALU_XOR, ALU_SLT, ALU_PASSB} alu_op_e;

  typedef struct packed {
    ext_sel_e ext;
    logic     b_imm;
    alu_op_e  alu;
    dst_sel_e dst;
    wb_sel_e  wb;
    pc_sel_e  pc;
    logic     reg_we;
    logic     mem_we;
  } ctrl_t;
endpackage

// File: rtl/sc_ctrl.sv
module sc_ctrl
  import sc_pkg::*;
(
  input  logic [OPC_W-1:0] opcode_i,
  input  logic [5:0]       func_i,
  input  logic             rs_zero_i,
  output ctrl_t            ctrl_o,
  output logic             illegal_o
);
  ctrl_t c;
  logic  bad;

  always_comb begin
    c   = '{ext: EXT_SIGN, b_imm: 1'b0, alu: ALU_ADD, dst: DST_RT,
            wb: WB_ALU, pc: PC_SEQ, reg_we: 1'b0, mem_we: 1'b0};
    bad = 1'b0;
    unique case (opcode_i)
      OPC_RTYPE: begin
        c.dst = DST_RD;
        unique case (func_i)
          FN_ADD:  begin c.alu = ALU_ADD; c.reg_we = 1'b1; end
          FN_SUB:  begin c.alu = ALU_SUB; c.reg_we = 1'b1; end
          FN_AND:  begin c.alu = ALU_AND; c.reg_we = 1'b1; end
          FN_OR:   begin c.alu = ALU_OR;  c.reg_we = 1'b1; end
          FN_XOR:  begin c.alu = ALU_XOR; c.reg_we = 1'b1; end
          FN_SLT:  begin c.alu = ALU_SLT; c.reg_we = 1'b1; end
          FN_JR:   c.pc = PC_REG;
          FN_JALR: begin c.pc = PC_REG; c.wb = WB_LINK; c.reg_we = 1'b1; end
          default: bad = 1'b1;
        endcase
      end
      OPC_ADDI: begin c.b_imm = 1'b1; c.reg_we = 1'b1; end
      OPC_SLTI: begin c.b_imm = 1'b1; c.alu = ALU_SLT; c.reg_we = 1'b1; end
      OPC_ANDI: begin c.b_imm = 1'b1; c.ext = EXT_ZERO; c.alu = ALU_AND; c.reg_we = 1'b1; end
      OPC_ORI:  begin c.b_imm = 1'b1; c.ext = EXT_ZERO; c.alu = ALU_OR;  c.reg_we = 1'b1; end
      OPC_XORI: begin c.b_imm = 1'b1; c.ext = EXT_ZERO; c.alu = ALU_XOR; c.reg_we = 1'b1; end
      OPC_LUI:  begin c.b_imm = 1'b1; c.ext = EXT_HIGH; c.alu = ALU_PASSB; c.reg_we = 1'b1; end
      OPC_LW:   begin c.b_imm = 1'b1; c.wb = WB_MEM; c.reg_we = 1'b1; end
      OPC_SW:   begin c.b_imm = 1'b1; c.mem_we = 1'b1; end
      OPC_BZ:   c.pc = rs_zero_i ? PC_BR : PC_SEQ;
      OPC_BNZ:  c.pc = rs_zero_i ? PC_SEQ : PC_BR;
      OPC_J:    c.pc = PC_ABS;
      OPC_JAL:  begin c.pc = PC_ABS; c.dst = DST_LINK; c.wb = WB_LINK; c.reg_we = 1'b1; end
      default:  bad = 1'b1;
    endcase
    ctrl_o    = c;
    illegal_o = bad;
  end

  always_comb begin
    if (illegal_o) begin
      p_illegal_noop_r11: assert (!ctrl_o.reg_we && !ctrl_o.mem_we && ctrl_o.pc == PC_SEQ);
    end
    if (ctrl_o.mem_we) begin
      p_store_no_regwr_r6: assert (!ctrl_o.reg_we && ctrl_o.pc == PC_SEQ);
    end
  end
endmodule

// File: rtl/sc_alu.sv
module sc_alu
  import sc_pkg::*;
#(
  parameter int DW = XLEN
) (
  input  logic [DW-1:0] a_i,
  input  logic [DW-1:0] b_i,
  input  alu_op_e       op_i,
  output logic [DW-1:0] y_o
);
  always_comb begin
    unique case (op_i)
      ALU_ADD:   y_o = a_i + b_i;
      ALU_SUB:   y_o = a_i - b_i;
      ALU_AND:   y_o = a_i & b_i;
      ALU_OR:    y_o = a_i | b_i;
      ALU_XOR:   y_o = a_i ^ b_i;
      ALU_SLT:   y_o = {{(DW-1){1'b0}}, ($signed(a_i) < $signed(b_i))};
      ALU_PASSB: y_o = b_i;
      default:   y_o = a_i + b_i;
    endcase
  end
endmodule

// File: rtl/sc_regfile.sv
module sc_regfile #(
  parameter int DW   = 32,
  parameter int NREG = 32,
  localparam int AW  = $clog2(NREG)
) (
  input  logic          clk,
  input  logic          rst_ni,
  input  logic          we_i,
  input  logic [AW-1:0] wa_i,
  input  logic [DW-1:0] wd_i,
  input  logic [AW-1:0] ra1_i,
  output logic [DW-1:0] rd1_o,
  input  logic [AW-1:0] ra2_i,
  output logic [DW-1:0] rd2_o
);
  logic [DW-1:0] mem [NREG];
  logic          wr_ok;

  assign wr_ok = we_i && (wa_i != '0);

  always_ff @(posedge clk) begin
    if (wr_ok) mem[wa_i] <= wd_i;
  end

  assign rd1_o = (ra1_i == '0) ? '0 : mem[ra1_i];
  assign rd2_o = (ra2_i == '0) ? '0 : mem[ra2_i];

  p_wr_readback_r2: assert property (@(posedge clk) disable iff (!rst_ni)
    ($past(we_i) && $past(wa_i) != '0 && ra1_i == $past(wa_i)) |-> rd1_o == $past(wd_i));

  p_zero_after_write_r1: assert property (@(posedge clk) disable iff (!rst_ni)
    ($past(we_i) && $past(wa_i) == '0 && ra2_i == '0) |-> rd2_o == '0);
endmodule

// File: rtl/sc_core.sv
module sc_core
  import sc_pkg::*;
#(
  parameter logic [XLEN-1:0] RESET_PC = '0
) (
  input  logic              clk,
  input  logic              rst_ni,
  output logic [XLEN-1:0]   imem_addr_o,
  input  logic [XLEN-1:0]   imem_rdata_i,
  output logic [XLEN-1:0]   dmem_addr_o,
  output logic [XLEN-1:0]   dmem_wdata_o,
  output logic              dmem_we_o,
  input  logic [XLEN-1:0]   dmem_rdata_i,
  output logic [XLEN-1:0]   dbg_pc_o,
  output logic              dbg_wr_en_o,
  output logic [RIDX_W-1:0] dbg_wr_idx_o,
  output logic [XLEN-1:0]   dbg_wr_data_o
);
  localparam int IMM_W = 16;
  localparam int JIDX_W = 26;
  localparam logic [RIDX_W-1:0] LINK_REG = RIDX_W'(NREG - 1);

  logic [1:0]        rst_sync_q;
  logic              run;
  logic [XLEN-1:0]   pc_q, pc_d, pc4, br_tgt, abs_tgt;
  logic [XLEN-1:0]   instr, rs_val, rt_val, imm_ext, imm_sx, opb, alu_y, wb_data;
  logic [RIDX_W-1:0] rs_idx, rt_idx, rd_idx, dst_idx;
  logic [OPC_W-1:0]  opcode;
  logic [IMM_W-1:0]  imm;
  ctrl_t             ctrl;
  logic              illegal, rf_we;
  logic              unused_bits;

  // reset: asserted asynchronously, released on the clock
  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) rst_sync_q <= 2'b00;
    else         rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign run = rst_sync_q[1];

  assign instr  = imem_rdata_i;
  assign opcode = instr[31:26];
  assign rs_idx = instr[25:21];
  assign rt_idx = instr[20:16];
  assign rd_idx = instr[15:11];
  assign imm    = instr[15:0];
  assign unused_bits = ^{instr[10:6], illegal};

  sc_ctrl u_ctrl (
    .opcode_i  (opcode),
    .func_i    (instr[5:0]),
    .rs_zero_i (rs_val == '0),
    .ctrl_o    (ctrl),
    .illegal_o (illegal)
  );

  sc_regfile #(.DW(XLEN), .NREG(NREG)) u_rf (
    .clk    (clk),
    .rst_ni (run),
    .we_i   (rf_we),
    .wa_i   (dst_idx),
    .wd_i   (wb_data),
    .ra1_i  (rs_idx),
    .rd1_o  (rs_val),
    .ra2_i  (rt_idx),
    .rd2_o  (rt_val)
  );

  assign imm_sx = {{(XLEN-IMM_W){imm[IMM_W-1]}}, imm};
  always_comb begin
    unique case (ctrl.ext)
      EXT_ZERO: imm_ext = {{(XLEN-IMM_W){1'b0}}, imm};
      EXT_HIGH: imm_ext = {imm, {(XLEN-IMM_W){1'b0}}};
      default:  imm_ext = imm_sx;
    endcase
  end
  assign opb = ctrl.b_imm ? imm_ext : rt_val;

  sc_alu #(.DW(XLEN)) u_alu (
    .a_i  (rs_val),
    .b_i  (opb),
    .op_i (ctrl.alu),
    .y_o  (alu_y)
  );

  // write-back routing
  always_comb begin
    unique case (ctrl.dst)
      DST_RD:   dst_idx = rd_idx;
      DST_LINK: dst_idx = LINK_REG;
      default:  dst_idx = rt_idx;
    endcase
    unique case (ctrl.wb)
      WB_MEM:  wb_data = dmem_rdata_i;
      WB_LINK: wb_data = pc4;
      default: wb_data = alu_y;
    endcase
  end
  assign rf_we = ctrl.reg_we && run;

  // next PC
  assign pc4     = pc_q + XLEN'(4);
  assign br_tgt  = pc4 + {imm_sx[XLEN-3:0], 2'b00};
  assign abs_tgt = {pc4[XLEN-1:JIDX_W+2], instr[JIDX_W-1:0], 2'b00};
  always_comb begin
    unique case (ctrl.pc)
      PC_BR:   pc_d = br_tgt;
      PC_REG:  pc_d = rs_val;
      PC_ABS:  pc_d = abs_tgt;
      default: pc_d = pc4;
    endcase
  end

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni)  pc_q <= RESET_PC;
    else if (run) pc_q <= pc_d;
  end

  assign imem_addr_o   = pc_q;
  assign dmem_addr_o   = alu_y;
  assign dmem_wdata_o  = rt_val;
  assign dmem_we_o     = ctrl.mem_we && run;
  assign dbg_pc_o      = pc_q;
  assign dbg_wr_en_o   = rf_we && (dst_idx != '0);
  assign dbg_wr_idx_o  = dst_idx;
  assign dbg_wr_data_o = wb_data;

  p_seq_advance_r11: assert property (@(posedge clk) disable iff (!run)
    (ctrl.pc == PC_SEQ) |=> pc_q == $past(pc_q) + XLEN'(4));

  p_branch_not_taken_r7: assert property (@(posedge clk) disable iff (!run)
    (opcode == OPC_BZ && rs_val != '0) |=> pc_q == $past(pc_q) + XLEN'(4));

  p_link_write_r8: assert property (@(posedge clk) disable iff (!run)
    (opcode == OPC_JAL) |-> (dbg_wr_en_o && dbg_wr_idx_o == LINK_REG && dbg_wr_data_o == pc_q + XLEN'(4)));

  p_reset_quiet_r12: assert property (@(posedge clk)
    !run |-> (!dmem_we_o && !dbg_wr_en_o && pc_q == RESET_PC));
endmodule

// File: tb/tb_sc_core.sv
module tb_sc_core;
  typedef struct packed {
    logic [31:0] pc;
    logic [4:0]  idx;
    logic [31:0] val;
  } item_t;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [31:0] imem_addr, imem_rdata, dmem_addr, dmem_wdata, dmem_rdata;
  logic        dmem_we;
  logic [31:0] dbg_pc, dbg_wr_data;
  logic        dbg_wr_en;
  logic [4:0]  dbg_wr_idx;

  logic [31:0] imem [64];
  logic [31:0] dmem [64];
  item_t       exp_q [$];
  string       tag_q [$];
  int          checks = 0;
  int          errors = 0;
  int          store_cnt = 0;
  int          slot = 0;
  bit          running = 1'b0;

  always #4 clk = ~clk;

  assign imem_rdata = imem[imem_addr[7:2]];
  assign dmem_rdata = dmem[dmem_addr[7:2]];

  sc_core dut (
    .clk           (clk),
    .rst_ni        (rst_n),
    .imem_addr_o   (imem_addr),
    .imem_rdata_i  (imem_rdata),
    .dmem_addr_o   (dmem_addr),
    .dmem_wdata_o  (dmem_wdata),
    .dmem_we_o     (dmem_we),
    .dmem_rdata_i  (dmem_rdata),
    .dbg_pc_o      (dbg_pc),
    .dbg_wr_en_o   (dbg_wr_en),
    .dbg_wr_idx_o  (dbg_wr_idx),
    .dbg_wr_data_o (dbg_wr_data)
  );

  task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  function automatic logic [31:0] enc_r(input logic [5:0] fn, input int rd, input int rs, input int rt);
    return {6'h00, 5'(rs), 5'(rt), 5'(rd), 5'd0, fn};
  endfunction
  function automatic logic [31:0] enc_i(input logic [5:0] op, input int rt, input int rs, input logic [15:0] im);
    return {op, 5'(rs), 5'(rt), im};
  endfunction
  function automatic logic [31:0] enc_j(input logic [5:0] op, input int target_slot);
    return {op, 26'(target_slot)};
  endfunction

  // driver: places an instruction and queues its expected register write
  task automatic emit(input logic [31:0] ins, input bit wr, input int rd, input logic [31:0] val, input string tag);
    item_t it;
    imem[slot] = ins;
    if (wr) begin
      it.pc  = 32'(slot * 4);
      it.idx = 5'(rd);
      it.val = val;
      exp_q.push_back(it);
      tag_q.push_back(tag);
    end
    slot++;
  endtask

  // monitor: pops expected writes as the core commits them
  always @(negedge clk) begin
    if (running && dbg_wr_en) begin
      if (exp_q.size() == 0) begin
        check(1'b0, "R10/R11 unexpected write", {27'd0, dbg_wr_idx}, 32'hFFFF_FFFF);
      end else begin
        item_t e;
        string t;
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        check(dbg_pc == e.pc, {t, " pc"}, dbg_pc, e.pc);
        check(dbg_wr_idx == e.idx, {t, " idx"}, {27'd0, dbg_wr_idx}, {27'd0, e.idx});
        check(dbg_wr_data == e.val, {t, " data"}, dbg_wr_data, e.val);
      end
    end
  end

  // data memory model with store checking (R6)
  always @(posedge clk) begin
    if (dmem_we) begin
      dmem[dmem_addr[7:2]] <= dmem_wdata;
      store_cnt++;
      check(dmem_addr == 32'd20 && dmem_wdata == 32'd8, "R6 store addr/data",
            dmem_addr, 32'd20);
    end
  end

  initial begin
    for (int i = 0; i < 64; i++) begin
      imem[i] = 32'hFC00_0000;
      dmem[i] = 32'h0;
    end
    dmem[0] = 32'hCAFE_F00D;

    emit(enc_i(6'h08, 1, 0, 16'd5),     1, 1, 32'd5, "R4 addi");
    emit(enc_i(6'h08, 2, 0, 16'hFFFD),  1, 2, 32'hFFFF_FFFD, "R4 addi neg");
    emit(enc_r(6'h20, 3, 1, 2),         1, 3, 32'd2, "R3 add");
    emit(enc_r(6'h22, 4, 1, 2),         1, 4, 32'd8, "R3 sub");
    emit(enc_r(6'h24, 5, 1, 2),         1, 5, 32'd5, "R3 and");
    emit(enc_r(6'h25, 6, 1, 2),         1, 6, 32'hFFFF_FFFD, "R3 or");
    emit(enc_r(6'h26, 7, 1, 2),         1, 7, 32'hFFFF_FFF8, "R3 xor");
    emit(enc_r(6'h2A, 8, 2, 1),         1, 8, 32'd1, "R3 slt signed");
    emit(enc_i(6'h0D, 9, 0, 16'h8000),  1, 9, 32'h0000_8000, "R4 ori zero-ext");
    emit(enc_i(6'h0F, 10, 0, 16'h1234), 1, 10, 32'h1234_0000, "R4 lui");
    emit(enc_i(6'h0A, 11, 2, 16'hFFFE), 1, 11, 32'd1, "R4 slti");
    emit(enc_i(6'h08, 0, 0, 16'd7),     0, 0, 32'd0, "R1 write r0");
    emit(enc_r(6'h20, 12, 0, 0),        1, 12, 32'd0, "R1 r0 reads zero");
    emit(enc_i(6'h08, 13, 0, 16'd16),   1, 13, 32'd16, "R2 base");
    emit(enc_i(6'h2B, 4, 13, 16'd4),    0, 0, 32'd0, "R6 sw");
    emit(enc_i(6'h23, 14, 13, 16'd4),   1, 14, 32'd8, "R5 lw after sw");
    emit(enc_i(6'h23, 15, 13, 16'hFFF0),1, 15, 32'hCAFE_F00D, "R5 lw neg disp");
    emit(enc_i(6'h04, 0, 0, 16'd1),     0, 0, 32'd0, "R7 beqz taken");
    emit(enc_i(6'h08, 16, 0, 16'd99),   0, 0, 32'd0, "R10 skipped");
    emit(enc_i(6'h05, 0, 0, 16'd5),     0, 0, 32'd0, "R7 bnez not taken");
    emit(enc_i(6'h05, 0, 1, 16'd1),     0, 0, 32'd0, "R7 bnez taken");
    emit(enc_i(6'h08, 16, 0, 16'd98),   0, 0, 32'd0, "R10 skipped");
    emit(enc_j(6'h03, 25),              1, 31, 32'd92, "R8 jal link");
    emit(enc_i(6'h08, 16, 0, 16'd97),   0, 0, 32'd0, "R10 skipped");
    emit(enc_i(6'h08, 16, 0, 16'd96),   0, 0, 32'd0, "R10 skipped");
    emit(enc_i(6'h08, 17, 0, 16'd112),  1, 17, 32'd112, "R8 jal target");
    emit(enc_r(6'h09, 18, 17, 0),       1, 18, 32'd108, "R9 jalr link");
    emit(enc_i(6'h08, 16, 0, 16'd95),   0, 0, 32'd0, "R10 skipped");
    emit(32'hFC21_0005,                 0, 0, 32'd0, "R11 unknown");
    emit(enc_j(6'h02, 31),              0, 0, 32'd0, "R8 j");
    emit(enc_i(6'h08, 16, 0, 16'd94),   0, 0, 32'd0, "R10 skipped");
    emit(enc_i(6'h08, 19, 0, 16'd1),    1, 19, 32'd1, "R9/R11 reached");
    emit(enc_j(6'h02, 32),              0, 0, 32'd0, "end loop");

    // reset behaviour (R12)
    repeat (3) @(negedge clk);
    check(dbg_pc == 32'd0, "R12 reset pc", dbg_pc, 32'd0);
    check(!dmem_we && !dbg_wr_en, "R12 quiet in reset", {31'd0, dmem_we | dbg_wr_en}, 32'd0);
    rst_n = 1'b1;
    running = 1'b1;
    @(negedge clk);
    check(dbg_pc == 32'd0, "R12 pc held during sync release", dbg_pc, 32'd0);

    begin : run_loop
      int cyc;
      cyc = 0;
      while (dbg_pc != 32'd128 && cyc < 2000) begin
        @(negedge clk);
        cyc++;
      end
      check(cyc < 2000, "R10 watchdog", 32'(cyc), 32'd2000);
    end
    repeat (3) @(negedge clk);

    check(exp_q.size() == 0, "R10 all expected writes seen", 32'(exp_q.size()), 32'd0);
    check(store_cnt == 1, "R6 single store", 32'(store_cnt), 32'd1);
    check(dmem[5] == 32'd8, "R6 stored word", dmem[5], 32'd8);
    check(dmem[0] == 32'hCAFE_F00D, "R11 memory untouched", dmem[0], 32'hCAFE_F00D);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule